// File: doc/BRIEF.md
# Generalized Bit-Reverse Permuter

This unit rearranges the bits of an operand by one rule: bit `i` of the result is taken from bit `i XOR k` of the source. The value `k` is a small key. Depending on `k`, this single rule produces a full bit reversal, a byte reversal, nibble or halfword swaps, or any mix of these. The key comes from a control operand or from a 6-bit immediate. The permutation covers either the whole datapath or only its lower half (word modes). In word modes the upper half of the result is zero. When the record flag is set, a 4-bit condition field accompanies the result.

Operations enter through a valid/ready stream and leave through a registered valid/ready stream. A transfer happens on a clock edge where both valid and ready are high. The input is ready whenever the output register is empty or is being drained in the same cycle, so back-pressure on the output stalls the input at once. While a result waits, it stays unchanged. Each accepted operation gives exactly one result, one cycle later, in the order of acceptance.

Top module: `grev_permuter`

## Requirements
- R1: Mode 2'b00 (full, control key): `out_result[i] = in_src[i ^ k]`, where `k = in_ctrl[L-1:0]` and `L = log2(WIDTH)`. Control bits above bit L-1 have no effect on the result.
- R2: Mode 2'b01 (full, immediate key): `k = in_imm[L-1:0]`, taken from the 6-bit immediate. `in_ctrl` has no effect.
- R3: Mode 2'b10 (word, control key): only `in_src[WIDTH/2-1:0]` is permuted, with `k = in_ctrl[L-2:0]`. The upper source half and the higher control bits have no effect.
- R4: Mode 2'b11 (word, immediate key): as in R3, but with `k = in_imm[L-2:0]`, taken from a 5-bit field. Immediate bit 5 and `in_ctrl` have no effect.
- R5: In both word modes (`in_mode[1]` = 1), `out_result[WIDTH-1:WIDTH/2]` is zero.
- R6: With `in_rec` = 1, `out_cond` holds, from bit 3 down to bit 0: {result negative, result positive, result zero, 0}, with the result read as a signed number. With `in_rec` = 0, `out_cond` is 4'b0000.
- R7: `in_ready` = !out_valid || out_ready. An operation accepted at one edge is presented at the next edge with `out_valid` = 1. Results leave in order of acceptance.
- R8: While `out_valid` = 1 and `out_ready` = 0, `out_valid`, `out_result` and `out_cond` stay unchanged.
- R9: While `rst_n` is low, and until the first accepted operation, `out_valid` is 0.
- R10: Known keys on 64 bits: k = 6'b111111 gives a complete bit reversal, and k = 6'b111000 gives a byte reversal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_src | input | WIDTH | Source operand |
| in_ctrl | input | WIDTH | Control operand supplying the key in register modes |
| in_imm | input | 6 | Immediate key field |
| in_mode | input | 2 | Mode: 00 full/control, 01 full/imm, 10 word/control, 11 word/imm |
| in_rec | input | 1 | Record flag requesting the condition field |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes result this cycle |
| out_result | output | WIDTH | Permuted result |
| out_cond | output | 4 | Condition field {neg, pos, zero, 0} |

## Verification
Every result is due exactly one edge after its operation is accepted. It then stays on the port for as many further edges as `out_ready` is held low. The bench drives inputs on the falling edge and samples on the next falling edge. It keeps expected results in a queue that is filled when an operation is accepted and drained when a result is taken. On every cycle, `out_valid` is compared with whether the queue holds anything, and the held result is compared with the head of the queue. `in_ready` is combinational, so it is checked one nanosecond after the inputs settle in the same cycle.

// File: rtl/grev_pkg.sv
package grev_pkg;
  localparam int IMM_W  = 6;
  localparam int COND_W = 4;

  typedef enum logic [1:0] {
    GM_FULL_REG = 2'b00,
    GM_FULL_IMM = 2'b01,
    GM_WORD_REG = 2'b10,
    GM_WORD_IMM = 2'b11
  } grev_mode_e;

  typedef struct packed {
    logic neg;
    logic pos;
    logic zer;
    logic rsv;
  } grev_cond_t;
endpackage

// File: rtl/grev_key_sel.sv
module grev_key_sel #(
  parameter int WIDTH = 64,
  localparam int LW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0]          ctrl,
  input  logic [grev_pkg::IMM_W-1:0] imm,
  input  grev_pkg::grev_mode_e      mode,
  output logic [LW-1:0]             key
);
  import grev_pkg::*;

  logic [WIDTH-LW-1:0] unused_ctrl_hi;
  logic [IMM_W-1:0]    unused_imm;
  assign unused_ctrl_hi = ctrl[WIDTH-1:LW];
  assign unused_imm     = imm;

  always_comb begin
    unique case (mode)
      GM_FULL_REG: key = ctrl[LW-1:0];
      GM_FULL_IMM: key = imm[LW-1:0];
      GM_WORD_REG: key = {1'b0, ctrl[LW-2:0]};
      default:     key = {1'b0, imm[LW-2:0]};
    endcase
  end
endmodule

// File: rtl/grev_net.sv
module grev_net #(
  parameter int WIDTH = 64,
  localparam int LW = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] din,
  input  logic [LW-1:0]    key,
  output logic [WIDTH-1:0] dout
);
  logic [LW:0][WIDTH-1:0] stg;

  assign stg[0] = din;

  for (genvar j = 0; j < LW; j++) begin : g_stage
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      assign stg[j+1][i] = key[j] ? stg[j][i ^ (1 << j)] : stg[j][i];
    end
  end

  assign dout = stg[LW];
endmodule

// File: rtl/grev_cond.sv
module grev_cond #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0]            res,
  input  logic                        rec,
  output logic [grev_pkg::COND_W-1:0] cond
);
  import grev_pkg::*;
  grev_cond_t c;

  always_comb begin
    c     = '0;
    c.zer = rec && (res == '0);
    c.neg = rec && res[WIDTH-1];
    c.pos = rec && !res[WIDTH-1] && (res != '0);
    c.rsv = 1'b0;
    cond  = c;
  end
endmodule

// File: rtl/grev_permuter.sv
module grev_permuter #(
  parameter int WIDTH = 64
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic [WIDTH-1:0]             in_src,
  input  logic [WIDTH-1:0]             in_ctrl,
  input  logic [grev_pkg::IMM_W-1:0]   in_imm,
  input  logic [1:0]                   in_mode,
  input  logic                         in_rec,
  output logic                         out_valid,
  input  logic                         out_ready,
  output logic [WIDTH-1:0]             out_result,
  output logic [grev_pkg::COND_W-1:0]  out_cond
);
  import grev_pkg::*;
  localparam int LW = $clog2(WIDTH);
  localparam int HW = WIDTH / 2;

  grev_mode_e        mode;
  logic [LW-1:0]     key;
  logic [WIDTH-1:0]  src_eff;
  logic [WIDTH-1:0]  perm;
  logic [COND_W-1:0] cond_d;
  logic              fire;

  logic              vld_q;
  logic [WIDTH-1:0]  res_q;
  logic [COND_W-1:0] cond_q;

  assign mode    = grev_mode_e'(in_mode);
  assign src_eff = in_mode[1] ? {{HW{1'b0}}, in_src[HW-1:0]} : in_src;

  grev_key_sel #(.WIDTH(WIDTH)) key_i (
    .ctrl (in_ctrl),
    .imm  (in_imm),
    .mode (mode),
    .key  (key)
  );

  grev_net #(.WIDTH(WIDTH)) net_i (
    .din  (src_eff),
    .key  (key),
    .dout (perm)
  );

  grev_cond #(.WIDTH(WIDTH)) cond_i (
    .res  (perm),
    .rec  (in_rec),
    .cond (cond_d)
  );

  assign in_ready = !vld_q || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else if (fire) begin
      vld_q <= 1'b1;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_q  <= '0;
      cond_q <= '0;
    end else if (fire) begin
      res_q  <= perm;
      cond_q <= cond_d;
    end
  end

  assign out_valid  = vld_q;
  assign out_result = res_q;
  assign out_cond   = cond_q;
endmodule

// File: rtl/grev_permuter_chk.sv
module grev_permuter_chk #(
  parameter int WIDTH = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic [WIDTH-1:0] in_src,
  input logic [1:0]       in_mode,
  input logic             in_rec,
  input logic             out_valid,
  input logic             out_ready,
  input logic [WIDTH-1:0] out_result,
  input logic [3:0]       out_cond
);
  logic fire;
  assign fire = in_valid && in_ready;

  // R1: a full-width permutation keeps the number of set bits
  a_r1_popcount: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_mode[1] |=> $countones(out_result) == $countones($past(in_src)));

  // R5: the word modes leave the upper half zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    fire && in_mode[1] |=> out_result[WIDTH-1:WIDTH/2] == '0);

  // R6: without the record flag the condition field is clear
  a_r6_norec: assert property (@(posedge clk) disable iff (!rst_n)
    fire && !in_rec |=> out_cond == 4'b0000);

  // R6: at most one of the three flags is set, and the low bit stays zero
  a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot0(out_cond) && !out_cond[0]);

  // R7: an accepted operation is presented at the next edge
  a_r7_present: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);

  // R7: a full, stalled output register blocks the input
  a_r7_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8: a stalled result is held unchanged
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_cond));
endmodule

bind grev_permuter grev_permuter_chk #(.WIDTH(WIDTH)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_src     (in_src),
  .in_mode    (in_mode),
  .in_rec     (in_rec),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_cond   (out_cond)
);

// File: tb/grev_permuter_tb_top.sv
`timescale 1ns/1ps
module grev_permuter_tb_top;
  localparam int W = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [W-1:0]  in_src = '0;
  logic [W-1:0]  in_ctrl = '0;
  logic [5:0]    in_imm = '0;
  logic [1:0]    in_mode = '0;
  logic          in_rec = 1'b0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [W-1:0]  out_result;
  logic [3:0]    out_cond;

  always #4 clk = ~clk;

  grev_permuter #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_src(in_src), .in_ctrl(in_ctrl), .in_imm(in_imm),
    .in_mode(in_mode), .in_rec(in_rec),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_cond(out_cond)
  );

  typedef struct {
    logic [W-1:0] res;
    logic [3:0]   cond;
    int           mode;
    bit           known;
    logic [W-1:0] kval;
    string        ktag;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   errors = 0;
  bit   done = 0;
  bit   prev_stall = 0;

  function automatic exp_t model(logic [W-1:0] src, logic [W-1:0] ctrl,
                                 logic [5:0] imm, int mode, bit rec);
    exp_t e;
    int k;
    logic [W-1:0] s;
    case (mode)
      0: k = int'(ctrl[5:0]);
      1: k = int'(imm);
      2: k = int'(ctrl[4:0]);
      default: k = int'(imm[4:0]);
    endcase
    s = (mode >= 2) ? {32'h0, src[31:0]} : src;
    e.res = '0;
    for (int i = 0; i < W; i++) e.res[i] = s[i ^ k];
    e.cond = 4'b0000;
    if (rec) begin
      if ($signed(e.res) < 0) e.cond = 4'b1000;
      else if ($signed(e.res) > 0) e.cond = 4'b0100;
      else e.cond = 4'b0010;
    end
    e.mode  = mode;
    e.known = 0;
    e.kval  = '0;
    e.ktag  = "";
    return e;
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle: check held outputs, apply new inputs, check ready, update model
  task automatic step(bit v, logic [W-1:0] src, logic [W-1:0] ctrl,
                      logic [5:0] imm, int mode, bit rec, bit ordy,
                      bit known = 0, logic [W-1:0] kval = '0, string ktag = "");
    exp_t e;
    bit fire;
    @(negedge clk);
    chk(out_valid == (q.size() != 0), "R7", W'(out_valid), W'(q.size() != 0));
    if (out_valid && q.size() != 0) begin
      e = q[0];
      chk(out_result == e.res, prev_stall ? "R8" : mode_tag(e.mode), out_result, e.res);
      if (e.mode >= 2)
        chk(out_result[W-1:W/2] == '0, "R5", out_result, e.res);
      chk(out_cond == e.cond, "R6", W'(out_cond), W'(e.cond));
      if (e.known) chk(out_result == e.kval, e.ktag, out_result, e.kval);
    end
    in_valid  = v;
    in_src    = src;
    in_ctrl   = ctrl;
    in_imm    = imm;
    in_mode   = 2'(mode);
    in_rec    = rec;
    out_ready = ordy;
    #1;
    chk(in_ready == (!out_valid || out_ready), "R7", W'(in_ready), W'(!out_valid || out_ready));
    fire = v && in_ready;
    prev_stall = out_valid && !ordy;
    if (out_valid && ordy && q.size() != 0) void'(q.pop_front());
    if (fire) begin
      e = model(src, ctrl, imm, mode, rec);
      e.known = known;
      e.kval  = kval;
      e.ktag  = ktag;
      q.push_back(e);
    end
  endtask

  initial begin
    #1600000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R9", W'(out_valid), '0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", W'(out_valid), '0);

    // R10: known keys
    step(1, 64'h0123456789ABCDEF, 64'h3F, 6'd0, 0, 1, 1, 1, 64'hF7B3D591E6A2C480, "R10");
    step(1, 64'h0123456789ABCDEF, 64'hFFFF_FF00_0000_0038, 6'd0, 0, 1, 1, 1, 64'hEFCDAB8967452301, "R10");
    step(1, 64'h0123456789ABCDEF, 64'h0, 6'h38, 1, 0, 1, 1, 64'hEFCDAB8967452301, "R10");
    // R3/R4/R5: word modes with a non-zero upper half and high key bits set
    step(1, 64'hDEADBEEF_00000001, 64'hFFFF_FFFF_FFFF_FFFF, 6'd0, 2, 1, 1, 1, 64'h0000_0000_8000_0000, "R3");
    step(1, 64'hDEADBEEF_000000FF, 64'h0, 6'h38, 3, 1, 1, 1, 64'h0000_0000_FF00_0000, "R4");
    // R6: zero and negative results
    step(1, 64'h0, 64'h15, 6'd0, 0, 1, 1);
    step(1, 64'h1, 64'h0, 6'h3F, 1, 1, 1);
    // R8: stall then drain
    step(1, 64'h00F0, 64'h4, 6'd0, 0, 1, 0);
    step(1, 64'h1234, 64'h8, 6'd0, 0, 1, 0);
    step(1, 64'h5678, 64'h8, 6'd0, 0, 1, 0);
    step(0, '0, '0, 6'd0, 0, 0, 1);
    step(0, '0, '0, 6'd0, 0, 0, 1);

    // Random traffic with back-pressure
    for (int n = 0; n < 3000; n++) begin
      step(($urandom % 10) < 7, {$urandom, $urandom}, {$urandom, $urandom},
           6'($urandom), int'($urandom % 4), 1'($urandom), ($urandom % 10) < 7);
    end
    for (int n = 0; n < 4; n++) step(0, '0, '0, 6'd0, 0, 0, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule